// File: doc/BRIEF.md
# Register-Mapped Block Cipher Front-End

This block lets a processor drive two block-cipher engines with nothing more than its model-specific register read and write operations. A 128-bit-block engine ("AES" path, 128-bit key) and a 64-bit-block engine ("DES" path, 56-bit key) sit behind generic start/done ports. Software first writes a control register. It picks the target engine, the direction, whether the next data writes carry key or input text, and which 64-bit chunk they fill. It then streams 64-bit words through a single data register. The write that completes an input block launches the chosen engine. When the engine signals done, the result is captured and software reads it back chunk by chunk through a result register. A status register reports per-engine busy, result-valid, the engine that produced the held result and a sticky error flag.

The register window has four words at a parameterised base address. No privilege qualification is applied to any access. Each step costs one clock: launching write to start, done to visible status, read to returned data. This keeps the round trip well within six cycles.

Top module: `crypto_msr_front`

## Requirements
- R1: The register window holds four words at BASE_ADDR: +0 control, +1 data, +2 result, +3 status. The control word has bit0 engine (0 = AES, 1 = DES), bit1 decrypt, bit2 key-select (1 = key, 0 = text) and bit3 chunk index (0 = bits 63:0, 1 = bits 127:64). Reading the control word returns those four bits with zeros above. Read data appears on msr_rdata_o in the cycle after msr_rd_i and is zero in every cycle without a read.
- R2: With engine AES and key-select 1, a data write stores the word into the AES key chunk named by the chunk index, shown on aes_key_o.
- R3: With engine DES and key-select 1, a data write stores only the low 56 bits of the word as the DES key.
- R4: With engine AES and key-select 0, a data write fills the named AES text chunk. Only a write with chunk index 1 starts the engine: aes_start_o is high for exactly the one cycle after that write. A chunk-0 text write starts nothing.
- R5: With engine DES and key-select 0, every accepted data write loads the DES input block and pulses des_start_o for the one cycle after the write.
- R6: The decrypt bit of the control word in force at a launch is held on that engine's decrypt output until its next launch.
- R7: Status bit0 (AES) and bit1 (DES) are 1 from the start pulse until the cycle after the engine's done input.
- R8: An engine's done captures its result. Status bit2 (result valid) is set in the cycle after done, and status bit4 shows the producing engine (0 = AES, 1 = DES). Result reads return the low chunk, then for AES the high chunk. Valid clears after the last chunk is read. A result read while valid is 0 returns zero.
- R9: Any engine launch clears result-valid.
- R10: A data write while the engine selected by the control word is busy is dropped: no staging change and no start. It sets status bit3, which stays set until a status write with bit3 = 1.
- R11: Reads of addresses outside the window return zero, and writes there change no register.
- R12: Reset clears control, staging, status and read data, and holds both start outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msr_wr_i | input | 1 | Register write strobe |
| msr_rd_i | input | 1 | Register read strobe |
| msr_addr_i | input | ADDR_W | Register address |
| msr_wdata_i | input | 64 | Write data |
| msr_rdata_o | output | 64 | Read data, one cycle after the read strobe |
| aes_start_o | output | 1 | One-cycle launch pulse, 128-bit engine |
| aes_decrypt_o | output | 1 | Direction for the 128-bit engine |
| aes_key_o | output | 128 | Staged 128-bit key |
| aes_data_o | output | 128 | Staged 128-bit input block |
| aes_done_i | input | 1 | Completion pulse from the 128-bit engine |
| aes_result_i | input | 128 | Result of the 128-bit engine |
| des_start_o | output | 1 | One-cycle launch pulse, 64-bit engine |
| des_decrypt_o | output | 1 | Direction for the 64-bit engine |
| des_key_o | output | 56 | Staged 56-bit key |
| des_data_o | output | 64 | Staged 64-bit input block |
| des_done_i | input | 1 | Completion pulse from the 64-bit engine |
| des_result_i | input | 64 | Result of the 64-bit engine |

## Verification
The bench uses the default parameters: a 12-bit address with the window at 0x0C0, 64-bit register words, and two chunks per 128-bit block. This puts chunk selection, partial-block writes that must not launch, and the two-read result drain within reach. The stub engines take 12 and 16 cycles. That leaves room to hit a busy engine with a rejected write, to launch one engine while the other's result is still held, and to poll status across the whole busy window.

// File: rtl/crypto_msr_pkg.sv
package crypto_msr_pkg;
  localparam int unsigned MSR_W      = 64;
  localparam int unsigned AES_KEY_W  = 128;
  localparam int unsigned AES_BLK_W  = 128;
  localparam int unsigned DES_KEY_W  = 56;
  localparam int unsigned DES_BLK_W  = 64;
  localparam int unsigned NUM_ENG    = 2;
  localparam int unsigned AES_CHUNKS = AES_BLK_W / MSR_W;
  localparam int unsigned CHUNK_W    = (AES_CHUNKS > 1) ? $clog2(AES_CHUNKS) : 1;
  localparam int unsigned RES_W      = (AES_BLK_W > DES_BLK_W) ? AES_BLK_W : DES_BLK_W;

  localparam int unsigned ST_AES_BUSY = 0;
  localparam int unsigned ST_DES_BUSY = 1;
  localparam int unsigned ST_VALID    = 2;
  localparam int unsigned ST_ERR      = 3;
  localparam int unsigned ST_RES_ENG  = 4;

  typedef enum logic {ENG_AES = 1'b0, ENG_DES = 1'b1} eng_e;

  // field order is software-visible: eng bit0, decrypt bit1, key_sel bit2, chunk bit3+
  typedef struct packed {
    logic [CHUNK_W-1:0] chunk;
    logic               key_sel;
    logic               decrypt;
    eng_e               eng;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_DATA, SEL_RESULT, SEL_STATUS
  } msr_sel_e;
endpackage

// File: rtl/crypto_msr_decode.sv
module crypto_msr_decode
  import crypto_msr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h0C0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output msr_sel_e          sel_o
);
  logic [ADDR_W-1:0] off;
  assign off = addr_i - BASE_ADDR;

  always_comb begin
    case (off)
      ADDR_W'(0): sel_o = SEL_CTRL;
      ADDR_W'(1): sel_o = SEL_DATA;
      ADDR_W'(2): sel_o = SEL_RESULT;
      ADDR_W'(3): sel_o = SEL_STATUS;
      default:    sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/crypto_msr_stage.sv
module crypto_msr_stage
  import crypto_msr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  ctrl_t                ctrl_i,
  input  logic [MSR_W-1:0]     wdata_i,
  output logic [AES_KEY_W-1:0] aes_key_o,
  output logic [AES_BLK_W-1:0] aes_data_o,
  output logic                 aes_dec_o,
  output logic [DES_KEY_W-1:0] des_key_o,
  output logic [DES_BLK_W-1:0] des_data_o,
  output logic                 des_dec_o,
  output logic [NUM_ENG-1:0]   launch_o
);
  localparam logic [CHUNK_W-1:0] LAST = CHUNK_W'(AES_CHUNKS - 1);

  logic is_aes;
  assign is_aes = (ctrl_i.eng == ENG_AES);

  assign launch_o[0] = we_i && is_aes && !ctrl_i.key_sel && (ctrl_i.chunk == LAST);
  assign launch_o[1] = we_i && !is_aes && !ctrl_i.key_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aes_key_o  <= '0;
      aes_data_o <= '0;
      aes_dec_o  <= 1'b0;
      des_key_o  <= '0;
      des_data_o <= '0;
      des_dec_o  <= 1'b0;
    end else if (we_i) begin
      if (is_aes) begin
        for (int c = 0; c < AES_CHUNKS; c++) begin
          if (ctrl_i.chunk == CHUNK_W'(c)) begin
            if (ctrl_i.key_sel) aes_key_o[c*MSR_W +: MSR_W]  <= wdata_i;
            else                aes_data_o[c*MSR_W +: MSR_W] <= wdata_i;
          end
        end
        if (launch_o[0]) aes_dec_o <= ctrl_i.decrypt;
      end else if (ctrl_i.key_sel) begin
        des_key_o <= wdata_i[DES_KEY_W-1:0];
      end else begin
        des_data_o <= wdata_i[DES_BLK_W-1:0];
        des_dec_o  <= ctrl_i.decrypt;
      end
    end
  end
endmodule

// File: rtl/crypto_msr_launch.sv
module crypto_msr_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      start_o <= launch_i;
      if (launch_i)    busy_o <= 1'b1;
      else if (done_i) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/crypto_msr_result.sv
module crypto_msr_result
  import crypto_msr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 aes_done_i,
  input  logic [AES_BLK_W-1:0] aes_result_i,
  input  logic                 des_done_i,
  input  logic [DES_BLK_W-1:0] des_result_i,
  input  logic                 launch_i,
  input  logic                 rd_i,
  output logic                 valid_o,
  output eng_e                 eng_o,
  output logic [MSR_W-1:0]     chunk_o
);
  logic [RES_W-1:0]   res_q;
  logic [CHUNK_W-1:0] ptr_q;
  logic [CHUNK_W-1:0] last;

  assign last    = (eng_o == ENG_AES) ? CHUNK_W'(AES_CHUNKS - 1) : '0;
  assign chunk_o = valid_o ? res_q[ptr_q*MSR_W +: MSR_W] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      ptr_q   <= '0;
      valid_o <= 1'b0;
      eng_o   <= ENG_AES;
    end else if (aes_done_i) begin
      res_q   <= RES_W'(aes_result_i);
      ptr_q   <= '0;
      valid_o <= 1'b1;
      eng_o   <= ENG_AES;
    end else if (des_done_i) begin
      res_q   <= RES_W'(des_result_i);
      ptr_q   <= '0;
      valid_o <= 1'b1;
      eng_o   <= ENG_DES;
    end else if (launch_i) begin
      valid_o <= 1'b0;
      ptr_q   <= '0;
    end else if (rd_i && valid_o) begin
      if (ptr_q == last) begin
        valid_o <= 1'b0;
        ptr_q   <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crypto_msr_front.sv
module crypto_msr_front
  import crypto_msr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h0C0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 msr_wr_i,
  input  logic                 msr_rd_i,
  input  logic [ADDR_W-1:0]    msr_addr_i,
  input  logic [MSR_W-1:0]     msr_wdata_i,
  output logic [MSR_W-1:0]     msr_rdata_o,
  output logic                 aes_start_o,
  output logic                 aes_decrypt_o,
  output logic [AES_KEY_W-1:0] aes_key_o,
  output logic [AES_BLK_W-1:0] aes_data_o,
  input  logic                 aes_done_i,
  input  logic [AES_BLK_W-1:0] aes_result_i,
  output logic                 des_start_o,
  output logic                 des_decrypt_o,
  output logic [DES_KEY_W-1:0] des_key_o,
  output logic [DES_BLK_W-1:0] des_data_o,
  input  logic                 des_done_i,
  input  logic [DES_BLK_W-1:0] des_result_i
);
  msr_sel_e           sel;
  ctrl_t              ctrl_q;
  logic [NUM_ENG-1:0] busy, launch, done, start;
  logic               data_wr, tgt_busy, stage_we, reject, err_q;
  logic               res_valid;
  eng_e               res_eng;
  logic [MSR_W-1:0]   res_chunk, status;

  crypto_msr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i(msr_addr_i), .sel_o(sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (msr_wr_i && sel == SEL_CTRL) ctrl_q <= ctrl_t'(msr_wdata_i[CTRL_W-1:0]);
  end

  assign data_wr  = msr_wr_i && (sel == SEL_DATA);
  assign tgt_busy = (ctrl_q.eng == ENG_DES) ? busy[1] : busy[0];
  assign stage_we = data_wr && !tgt_busy;
  assign reject   = data_wr && tgt_busy;

  crypto_msr_stage u_stage (
    .clk_i, .rst_ni,
    .we_i(stage_we), .ctrl_i(ctrl_q), .wdata_i(msr_wdata_i),
    .aes_key_o, .aes_data_o, .aes_dec_o(aes_decrypt_o),
    .des_key_o, .des_data_o, .des_dec_o(des_decrypt_o),
    .launch_o(launch)
  );

  assign done = {des_done_i, aes_done_i};

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    crypto_msr_launch u_launch (
      .clk_i, .rst_ni,
      .launch_i(launch[g]), .done_i(done[g]),
      .start_o(start[g]), .busy_o(busy[g])
    );
  end

  assign aes_start_o = start[0];
  assign des_start_o = start[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (reject) err_q <= 1'b1;
    else if (msr_wr_i && sel == SEL_STATUS && msr_wdata_i[ST_ERR]) err_q <= 1'b0;
  end

  crypto_msr_result u_res (
    .clk_i, .rst_ni,
    .aes_done_i, .aes_result_i, .des_done_i, .des_result_i,
    .launch_i(|launch), .rd_i(msr_rd_i && sel == SEL_RESULT),
    .valid_o(res_valid), .eng_o(res_eng), .chunk_o(res_chunk)
  );

  always_comb begin
    status              = '0;
    status[ST_AES_BUSY] = busy[0];
    status[ST_DES_BUSY] = busy[1];
    status[ST_VALID]    = res_valid;
    status[ST_ERR]      = err_q;
    status[ST_RES_ENG]  = (res_eng == ENG_DES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msr_rdata_o <= '0;
    else if (!msr_rd_i) msr_rdata_o <= '0;
    else begin
      case (sel)
        SEL_CTRL:   msr_rdata_o <= {{(MSR_W-CTRL_W){1'b0}}, ctrl_q};
        SEL_RESULT: msr_rdata_o <= res_chunk;
        SEL_STATUS: msr_rdata_o <= status;
        default:    msr_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/crypto_msr_chk.sv
module crypto_msr_chk
  import crypto_msr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msr_wr_i,
  input logic               msr_rd_i,
  input msr_sel_e           sel_i,
  input logic [MSR_W-1:0]   msr_rdata_o,
  input logic               aes_start_o,
  input logic               des_start_o,
  input logic               aes_done_i,
  input logic               des_done_i,
  input logic [NUM_ENG-1:0] busy_i,
  input logic               err_i,
  input logic               valid_i
);
  // R4
  aes_start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aes_start_o |=> !aes_start_o);
  // R5
  des_start_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    des_start_o |-> $past(msr_wr_i));
  // R7
  aes_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aes_start_o |-> busy_i[0]);
  // R7
  des_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    des_start_o |-> busy_i[1]);
  // R8
  done_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aes_done_i || des_done_i) |=> valid_i);
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !(msr_wr_i && sel_i == SEL_STATUS)) |=> err_i);
  // R11
  unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && sel_i == SEL_NONE) |=> (msr_rdata_o == '0));
  // R1
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msr_rd_i |=> (msr_rdata_o == '0));
  // R12
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_start_chk: assert (!aes_start_o && !des_start_o);
    end
  end
endmodule

bind crypto_msr_front crypto_msr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .msr_wr_i(msr_wr_i), .msr_rd_i(msr_rd_i), .sel_i(sel),
  .msr_rdata_o(msr_rdata_o),
  .aes_start_o(aes_start_o), .des_start_o(des_start_o),
  .aes_done_i(aes_done_i), .des_done_i(des_done_i),
  .busy_i(busy), .err_i(err_q), .valid_i(res_valid)
);

// File: tb/crypto_msr_front_test.sv
module crypto_msr_front_test;
  localparam logic [11:0] BASE = 12'h0C0;
  localparam logic [11:0] A_CTRL = BASE, A_DATA = BASE + 12'd1,
                          A_RES = BASE + 12'd2, A_STAT = BASE + 12'd3;
  localparam int AES_LAT = 12, DES_LAT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [11:0]  addr = '0;
  logic [63:0]  wdata = '0, rdata;
  logic         aes_start, aes_dec, aes_done, des_start, des_dec, des_done;
  logic [127:0] aes_key, aes_data, aes_res;
  logic [55:0]  des_key;
  logic [63:0]  des_data, des_res;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  crypto_msr_front uut (
    .clk_i(clk), .rst_ni(rst_n), .msr_wr_i(wr), .msr_rd_i(rd),
    .msr_addr_i(addr), .msr_wdata_i(wdata), .msr_rdata_o(rdata),
    .aes_start_o(aes_start), .aes_decrypt_o(aes_dec), .aes_key_o(aes_key),
    .aes_data_o(aes_data), .aes_done_i(aes_done), .aes_result_i(aes_res),
    .des_start_o(des_start), .des_decrypt_o(des_dec), .des_key_o(des_key),
    .des_data_o(des_data), .des_done_i(des_done), .des_result_i(des_res)
  );

  function automatic logic [127:0] aes_model(logic [127:0] k, logic [127:0] d, logic dec);
    return dec ? ~(d ^ k) : ({d[63:0], d[127:64]} ^ k);
  endfunction
  function automatic logic [63:0] des_model(logic [55:0] k, logic [63:0] d, logic dec);
    return dec ? (d ^ {8'hA5, k}) : (~d ^ {8'h00, k});
  endfunction
  function automatic logic [63:0] cw(logic eng, logic dec, logic key, logic chunk);
    return {60'd0, chunk, key, dec, eng};
  endfunction

  // fixed-latency engine stubs
  int aes_cnt = 0, des_cnt = 0;
  logic [127:0] aes_kl = '0, aes_dl = '0;
  logic [55:0]  des_kl = '0;
  logic [63:0]  des_dl = '0;
  logic aes_decl = 1'b0, des_decl = 1'b0;
  always @(posedge clk) begin
    if (aes_start) begin
      aes_cnt <= AES_LAT; aes_kl <= aes_key; aes_dl <= aes_data; aes_decl <= aes_dec;
    end else if (aes_cnt > 0) aes_cnt <= aes_cnt - 1;
    if (des_start) begin
      des_cnt <= DES_LAT; des_kl <= des_key; des_dl <= des_data; des_decl <= des_dec;
    end else if (des_cnt > 0) des_cnt <= des_cnt - 1;
  end
  assign aes_done = (aes_cnt == 1);
  assign des_done = (des_cnt == 1);
  assign aes_res  = aes_model(aes_kl, aes_dl, aes_decl);
  assign des_res  = des_model(des_kl, des_dl, des_decl);

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [11:0] a, logic [63:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [11:0] a, output logic [63:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_valid(string req);
    logic [63:0] s;
    bit got = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      rd_reg(A_STAT, s);
      got = s[2];
    end
    chk(req, got, 1'b1);
  endtask

  task automatic aes_load(logic [127:0] k, logic [127:0] d, logic dec);
    wr_reg(A_CTRL, cw(0, dec, 1, 0)); wr_reg(A_DATA, k[63:0]);
    wr_reg(A_CTRL, cw(0, dec, 1, 1)); wr_reg(A_DATA, k[127:64]);
    wr_reg(A_CTRL, cw(0, dec, 0, 0)); wr_reg(A_DATA, d[63:0]);
    chk("R4 no start on low chunk", aes_start, 1'b0);
    wr_reg(A_CTRL, cw(0, dec, 0, 1)); wr_reg(A_DATA, d[127:64]);
    chk("R4 start after high chunk", aes_start, 1'b1);
  endtask

  task automatic aes_drain(logic [127:0] exp);
    logic [63:0] lo, hi, s;
    rd_reg(A_STAT, s);
    chk("R8 result engine AES", s[4], 1'b0);
    rd_reg(A_RES, lo); rd_reg(A_RES, hi);
    chk("R8 AES result", {hi, lo}, exp);
    rd_reg(A_STAT, s);
    chk("R8 valid cleared after AES drain", s[2], 1'b0);
  endtask

  task automatic des_run(logic [63:0] k, logic [63:0] d, logic dec);
    logic [63:0] r, s;
    wr_reg(A_CTRL, cw(1, dec, 1, 0)); wr_reg(A_DATA, k);
    chk("R3 DES key low 56", des_key, k[55:0]);
    wr_reg(A_CTRL, cw(1, dec, 0, 0)); wr_reg(A_DATA, d);
    chk("R5 DES start", des_start, 1'b1);
    chk("R6 DES decrypt", des_dec, dec);
    wait_valid("R8 DES valid");
    rd_reg(A_STAT, s);
    chk("R8 result engine DES", s[4], 1'b1);
    rd_reg(A_RES, r);
    chk("R8 DES result", r, des_model(k[55:0], d, dec));
    rd_reg(A_STAT, s);
    chk("R8 valid cleared after DES read", s[2], 1'b0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [63:0] s, r;
    logic [127:0] k, d, k2, d2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 start low", {aes_start, des_start}, 2'b00);
    chk("R12 aes key", aes_key, '0);
    chk("R12 des data", des_data, '0);
    chk("R12 rdata", rdata, '0);
    rd_reg(A_STAT, s); chk("R12 status", s, '0);
    rd_reg(A_CTRL, s); chk("R12 ctrl", s, '0);

    // R1 control readback masks to four bits
    wr_reg(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(A_CTRL, s); chk("R1 ctrl readback", s, 64'hF);
    wr_reg(A_CTRL, cw(0, 1, 1, 0));
    rd_reg(A_CTRL, s); chk("R1 ctrl fields", s, 64'h6);
    @(negedge clk); chk("R1 idle rdata zero", rdata, '0);

    // R8 result read with nothing valid
    rd_reg(A_RES, r); chk("R8 empty result read", r, '0);

    // R2 R4 R6 directed AES
    k = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    d = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEED_FACE;
    aes_load(k, d, 1'b0);
    chk("R2 AES key chunks", aes_key, k);
    chk("R4 AES data staged", aes_data, d);
    chk("R6 AES decrypt", aes_dec, 1'b0);
    @(negedge clk); chk("R4 start one cycle", aes_start, 1'b0);
    rd_reg(A_STAT, s); chk("R7 AES busy", s[1:0], 2'b01);

    // R10 rejected write while busy
    wr_reg(A_CTRL, cw(0, 1, 0, 1)); wr_reg(A_DATA, 64'h1234_5678_9ABC_DEF0);
    chk("R10 no start when busy", aes_start, 1'b0);
    chk("R10 staging held", aes_data, d);
    rd_reg(A_STAT, s); chk("R10 err set", s[3], 1'b1);
    wait_valid("R8 AES valid");
    rd_reg(A_STAT, s); chk("R7 AES idle after done", s[0], 1'b0);
    chk("R10 err sticky", s[3], 1'b1);
    aes_drain(aes_model(k, d, 1'b0));
    wr_reg(A_STAT, 64'h8);
    rd_reg(A_STAT, s); chk("R10 err cleared", s[3], 1'b0);

    // R9 a launch clears a held result
    aes_load(~k, d, 1'b1);
    chk("R6 AES decrypt set", aes_dec, 1'b1);
    wait_valid("R9 AES valid before DES launch");
    wr_reg(A_CTRL, cw(1, 0, 0, 0)); wr_reg(A_DATA, 64'h55);
    rd_reg(A_STAT, s);
    chk("R9 valid cleared by launch", s[2], 1'b0);
    chk("R7 DES busy", s[1], 1'b1);
    wait_valid("R9 DES valid");
    rd_reg(A_RES, r); chk("R9 DES result", r, des_model(56'd0, 64'h55, 1'b0));

    // R3 R5 DES with garbage in the top byte of the key word
    des_run(64'hFF12_3456_789A_BCDE, 64'h0F0F_1E1E_2D2D_3C3C, 1'b1);

    // R11 unmapped accesses
    wr_reg(A_CTRL, cw(0, 0, 1, 0));
    wr_reg(BASE + 12'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_reg(12'h000, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(A_CTRL, s); chk("R11 ctrl untouched", s, 64'h4);
    chk("R11 key untouched", aes_key, ~k);
    rd_reg(A_STAT, s); chk("R11 status untouched", s, 64'h10);
    rd_reg(BASE + 12'd5, r); chk("R11 unmapped read zero", r, '0);
    rd_reg(12'hFFF, r); chk("R11 unmapped high read zero", r, '0);

    // random operations on both engines
    for (int i = 0; i < 16; i++) begin
      logic dec;
      dec = 1'($urandom);
      if ($urandom % 2) begin
        k2 = {$urandom, $urandom, $urandom, $urandom};
        d2 = {$urandom, $urandom, $urandom, $urandom};
        aes_load(k2, d2, dec);
        wait_valid("R8 random AES valid");
        aes_drain(aes_model(k2, d2, dec));
      end else begin
        des_run({$urandom, $urandom}, {$urandom, $urandom}, dec);
      end
    end
    finish_run();
  end
endmodule